// File: doc/BRIEF.md
# Flash Command and Status Front End

This block is the register front end of an on-chip flash controller. Software reaches it over a simple synchronous bus with single-cycle read and write strobes. The block holds three control registers: mode, address and data. It also has a write-only command port and a read-only status word. When the command port receives a mass-erase code, the block first checks a key spread across the other registers. Only when that key matches does it raise a level request to the flash array. It then holds that request until the array answers with a done pulse and an error flag.

The status word reports busy, success, failure and an interrupt flag. The success, failure and interrupt flags are sticky, and reading the status word clears them as a side effect. If a flag is set in the same cycle as a status read, the set wins. The interrupt output follows the interrupt flag. Its purpose is to let software issue a mass erase safely: read status to flush old flags, arm the mode bit, load the two key words, write the erase code, then wait for busy to drop.

Top module: `flashctl_front`

## Requirements
- R1: After reset the status word reads 0x0000, the interrupt output and the erase request are low, and the mode, address and data registers read zero.
- R2: Register select codes are 0 for status (read only), 1 for mode, 2 for address, 3 for data and 4 for command (write only). Mode, address and data read back what was written. A read of select 4 returns zero.
- R3: A write to select 4 whose low 8 bits are 0x06 raises the erase request on the next clock edge, but only when mode bit 3 is set, the address register holds 0xFFC3 and the data register holds 0x3CFF.
- R4: Status bit 2 (busy) is high from the edge that accepts a command until the edge at which the array's done input is sampled high. Reads do not change it. A done pulse while idle has no effect.
- R5: When done is sampled with the error input low, status bit 0 (success) is set on that same edge. Busy and the erase request drop on that edge.
- R6: When done is sampled with the error input high, status bit 1 (fail) is set on that same edge.
- R7: A command write that is an unknown code, or the erase code without the full key, raises no request. It holds busy for one cycle and sets the fail flag on the second edge after the write.
- R8: Status bit 3 is set whenever success or fail is set while mode bit 4 is high, and never otherwise. The interrupt output equals status bit 3.
- R9: A status read returns the current flags, and bits 0, 1 and 3 are cleared on the edge that ends the read.
- R10: If a flag is being set on the same edge that a status read would clear it, the flag ends up set.
- R11: Writes to the mode, address, data or command selects are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| erase_req | output | 1 | Mass-erase request to the array, held until done |
| erase_done | input | 1 | One-cycle completion pulse from the array |
| erase_err | input | 1 | Error qualifier, sampled with erase_done |
| irq | output | 1 | Interrupt level, equal to status bit 3 |

## Verification
Suppose the sequencer state is wrong: a key mismatch that is accepted, or a busy that never drops. The erase request port shows the first case one edge after the command write. The second shows up in the next status read, so a read placed right after each command exposes it within two cycles. A wrong sticky flag, such as one not cleared by a read or lost when a set collides with a read, is visible on the very next status read. Reading status twice in a row after every completion therefore separates a correct clear from a missing or repeated one.

// File: rtl/flashctl_pkg.sv
// Shared constants for the flash command front end.
// Assumes a 3-bit register select and a 16-bit data path.
package flashctl_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MODE   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ADDR   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DATA   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CMD    = 3'd4;

    localparam int MODE_ARM_BIT = 3;
    localparam int MODE_IEN_BIT = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_REJECT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/flashctl_regs.sv
// Control register file: mode, address and data.
// Assumes single-cycle write strobes; every write is dropped while busy is high.
module flashctl_regs
    import flashctl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              busy,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    logic wr_ok;
    assign wr_ok = wr && !busy;

    // Load the selected control register on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_ok) begin
            if (sel == SEL_MODE) mode_q <= wdata;
            if (sel == SEL_ADDR) addr_q <= wdata;
            if (sel == SEL_DATA) data_q <= wdata;
        end
    end

    assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && busy) |=> ($stable(mode_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/flashctl_seq.sv
// Command sequencer: checks the erase key, runs the request/done handshake
// with the array and emits one-cycle success and fail events.
// Assumes erase_done is a single-cycle pulse, sampled only while erasing.
module flashctl_seq
    import flashctl_pkg::*;
#(
    parameter int              DATA_W     = 16,
    parameter int              CMD_W      = 8,
    parameter logic [CMD_W-1:0] ERASE_CODE = 8'h06,
    parameter logic [DATA_W-1:0] KEY_ADDR  = 16'hFFC3,
    parameter logic [DATA_W-1:0] KEY_DATA  = 16'h3CFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              arm,
    input  logic [DATA_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    input  logic              erase_done,
    input  logic              erase_err,
    output logic              erase_req,
    output logic              busy,
    output logic              ok_evt,
    output logic              fail_evt
);
    seq_state_t state;
    logic key_ok;
    logic erase_go;

    assign key_ok   = arm && (addr_q == KEY_ADDR) && (data_q == KEY_DATA);
    assign erase_go = (cmd_code == ERASE_CODE) && key_ok;

    // Advance the command state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (cmd_wr) state <= erase_go ? ST_ERASE : ST_REJECT;
                ST_ERASE:  if (erase_done) state <= ST_IDLE;
                ST_REJECT: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Decode outputs and completion events from the state.
    always_comb begin
        erase_req = (state == ST_ERASE);
        busy      = (state != ST_IDLE);
        ok_evt    = (state == ST_ERASE) && erase_done && !erase_err;
        fail_evt  = ((state == ST_ERASE) && erase_done && erase_err) || (state == ST_REJECT);
    end

    assert_req_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_req) |-> $past(cmd_wr && key_ok && (cmd_code == ERASE_CODE)));
    assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done) |=> busy);
    assert_reject_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REJECT) |=> !busy);
    assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_evt && fail_evt));
endmodule

// File: rtl/flashctl_status.sv
// Sticky status flags: success, fail and interrupt.
// A read clears them on its closing edge; a same-edge set takes priority.
module flashctl_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_evt,
    input  logic fail_evt,
    input  logic ien,
    input  logic rd_clr,
    output logic ok_q,
    output logic fail_q,
    output logic irq_q
);
    logic any_evt;
    assign any_evt = ok_evt || fail_evt;

    // Set on events, clear on status read, set dominant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            ok_q   <= ok_evt   || (ok_q   && !rd_clr);
            fail_q <= fail_evt || (fail_q && !rd_clr);
            irq_q  <= (ien && any_evt) || (irq_q && !rd_clr);
        end
    end

    assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !any_evt) |=> (!ok_q && !fail_q && !irq_q));
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_evt && rd_clr) |=> ok_q);
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(ien && any_evt));
endmodule

// File: rtl/flashctl_front.sv
// Flash command front end: register file, erase-key sequencer and sticky
// status behind a one-cycle strobe bus. Read data is combinational in the
// cycle of the read strobe; the status read clears flags at that cycle's end.
module flashctl_front
    import flashctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_sel,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [15:0]       bus_rdata,
    output logic              erase_req,
    input  logic              erase_done,
    input  logic              erase_err,
    output logic              irq
);
    localparam int PAD_W = DATA_W - 4;

    logic [DATA_W-1:0] mode_q, addr_q, data_q;
    logic busy, ok_evt, fail_evt;
    logic ok_q, fail_q, irq_q;
    logic cmd_wr, stat_rd;

    assign cmd_wr  = bus_wr && (bus_sel == SEL_CMD);
    assign stat_rd = bus_rd && (bus_sel == SEL_STATUS);

    flashctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wdata(bus_wdata),
        .wr(bus_wr), .busy(busy),
        .mode_q(mode_q), .addr_q(addr_q), .data_q(data_q)
    );

    flashctl_seq #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .cmd_code(bus_wdata[CMD_W-1:0]), .arm(mode_q[MODE_ARM_BIT]),
        .addr_q(addr_q), .data_q(data_q),
        .erase_done(erase_done), .erase_err(erase_err),
        .erase_req(erase_req), .busy(busy), .ok_evt(ok_evt), .fail_evt(fail_evt)
    );

    flashctl_status u_stat (
        .clk(clk), .rst_n(rst_n), .ok_evt(ok_evt), .fail_evt(fail_evt),
        .ien(mode_q[MODE_IEN_BIT]), .rd_clr(stat_rd),
        .ok_q(ok_q), .fail_q(fail_q), .irq_q(irq_q)
    );

    // Read multiplexer over the register selects.
    always_comb begin
        case (bus_sel)
            SEL_STATUS: bus_rdata = {{PAD_W{1'b0}}, irq_q, busy, fail_q, ok_q};
            SEL_MODE:   bus_rdata = mode_q;
            SEL_ADDR:   bus_rdata = addr_q;
            SEL_DATA:   bus_rdata = data_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = irq_q;

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == SEL_STATUS) |-> (bus_rdata[3] == irq));
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done && !busy) |=> !erase_req);
endmodule

// File: tb/flashctl_front_test.sv
module flashctl_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        erase_req;
    logic        erase_done = 1'b0;
    logic        erase_err = 1'b0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    localparam logic [15:0] KADDR = 16'hFFC3;
    localparam logic [15:0] KDATA = 16'h3CFF;

    always #10 clk = ~clk;

    flashctl_front uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .erase_req(erase_req), .erase_done(erase_done), .erase_err(erase_err),
        .irq(irq)
    );

    function automatic logic [15:0] stat_word(logic ie, logic bz, logic fl, logic ok);
        return {12'h000, ie, bz, fl, ok};
    endfunction

    function automatic bit key_match(logic [15:0] m, logic [15:0] a, logic [15:0] d, logic [7:0] c);
        return m[3] && a == KADDR && d == KDATA && c == 8'h06;
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] s, logic [15:0] v);
        bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] s, output logic [15:0] v);
        bus_sel = s; bus_rd = 1'b1;
        #1 v = bus_rdata;
        cyc();
        bus_rd = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        repeat (3) cyc();
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 status", v, 16'h0000);
        chk("R1 req", {15'd0, erase_req}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        rd(3'd1, v); chk("R1 mode", v, 16'h0000);
        // R2 command select reads zero
        wr(3'd2, 16'h1234);
        rd(3'd2, v); chk("R2 addr readback", v, 16'h1234);
        rd(3'd4, v); chk("R2 cmd reads zero", v, 16'h0000);

        // R4 done pulse while idle has no effect
        erase_done = 1'b1; cyc(); erase_done = 1'b0;
        rd(3'd0, v); chk("R4 idle done ignored", v, 16'h0000);

        // R10 directed: status read collides with done
        wr(3'd1, 16'h0018); wr(3'd2, KADDR); wr(3'd3, KDATA); wr(3'd4, 16'h0006);
        chk("R3 req raised", {15'd0, erase_req}, 16'd1);
        bus_sel = 3'd0; bus_rd = 1'b1; erase_done = 1'b1; erase_err = 1'b0;
        #1 v = bus_rdata;
        chk("R4 busy during read", v, stat_word(0, 1, 0, 0));
        cyc(); bus_rd = 1'b0; erase_done = 1'b0;
        rd(3'd0, v); chk("R10 set wins over read", v, stat_word(1, 0, 0, 1));
        rd(3'd0, v); chk("R9 cleared after read", v, 16'h0000);

        // Random sequences
        for (int it = 0; it < 200; it++) begin
            logic [15:0] m, a, d;
            logic [7:0]  c;
            bit acc;
            m = 16'($urandom);
            m[3] = ($urandom % 4) != 0;
            a = (($urandom % 4) != 0) ? KADDR : 16'($urandom);
            d = (($urandom % 4) != 0) ? KDATA : 16'($urandom);
            c = (($urandom % 4) != 0) ? 8'h06 : 8'($urandom);
            acc = key_match(m, a, d, c);
            wr(3'd1, m); wr(3'd2, a); wr(3'd3, d);
            rd(3'd1, v); chk("R2 mode readback", v, m);
            wr(3'd4, {8'($urandom), c});
            if (acc) begin
                bit er;
                chk("R3 request", {15'd0, erase_req}, 16'd1);
                rd(3'd0, v); chk("R4 busy", v, stat_word(0, 1, 0, 0));
                wr(3'd1, ~m);
                wr(3'd4, 16'h0006);
                rd(3'd1, v); chk("R11 mode held while busy", v, m);
                repeat ($urandom % 4) cyc();
                chk("R4 still busy", {15'd0, erase_req}, 16'd1);
                er = $urandom % 2;
                erase_done = 1'b1; erase_err = er;
                cyc();
                erase_done = 1'b0; erase_err = 1'b0;
                chk("R5 req dropped", {15'd0, erase_req}, 16'd0);
                chk("R8 irq out", {15'd0, irq}, {15'd0, m[4]});
                rd(3'd0, v);
                chk(er ? "R6 fail flag" : "R5 success flag", v, stat_word(m[4], 0, er, !er));
            end else begin
                chk("R7 no request", {15'd0, erase_req}, 16'd0);
                rd(3'd0, v); chk("R7 busy one cycle", v, stat_word(0, 1, 0, 0));
                rd(3'd0, v); chk("R7 fail flag", v, stat_word(m[4], 0, 1, 0));
            end
            rd(3'd0, v); chk("R9 flags cleared", v, 16'h0000);
            chk("R8 irq cleared", {15'd0, irq}, 16'd0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule